// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches up to eight external interrupt pins. Each pin first passes through a synchroniser. The pin's configured condition is then detected: a rising edge, a falling edge, both edges, an active-low level or an active-high level. A detected condition is latched as a pending request. A request reaches the processor only when the pin is unmasked and its priority field is nonzero. The controller drives one interrupt line per pin and also one combined line, which serves designs that route every pin to a single shared interrupt input.

Software reaches the controller through a simple single-cycle bus. Writes commit on the clock edge and reads return data combinationally in the same cycle. Six addresses are decoded:

| Address | Register |
|---|---|
| 0 | sense |
| 1 | priority |
| 2 | pending-source |
| 3 | mask-set (write-only) |
| 4 | mask-clear (write-only) |
| 5 | mode |

Per-pin fields are packed from the most significant end of each register, so pin 0 always occupies the highest field or bit.

Top module: `pinirq_ctrl`

## Requirements
- R1: After reset every pin is masked, all priority fields are 0, all pending bits are clear, the sense and mode registers read 0, and both interrupt outputs are low.
- R2: The sense register (address 0) is 32 bits and holds a SENSE_W-bit field per pin, with pin n at bits starting at 32-(n+1)*SENSE_W. The priority register (address 1) holds a 4-bit field per pin, with pin n at bits starting at 32-(n+1)*4. Both registers read back what was written.
- R3: Sense code 1 latches a rising edge, code 0 latches a falling edge and code 4 latches either edge. A pin change shows in the pending bit and on the outputs after the third rising clock edge.
- R4: Sense code 3 (active high) and code 2 (active low) set the pending bit on every cycle in which the synchronised level is active. A clear that is written while the level is still active therefore does not stick.
- R5: Sense codes other than 0 to 4 never set a pending bit.
- R6: The source register (address 2, SRC_W bits wide) holds pin n's pending bit at bit SRC_W-1-n. A write clears every pending bit written as 0 and leaves every bit written as 1 unchanged. A detection in the same cycle takes precedence over the clear.
- R7: The mask-set register (address 3) and the mask-clear register (address 4) use the same reversed bit order. A 1 masks or unmasks the pin and a 0 has no effect. Both registers read 0.
- R8: A pin whose priority field is 0 raises no interrupt. Any nonzero value lets the pin through.
- R9: irq_any_o is high when any pin is pending, unmasked and has a nonzero priority.
- R10: The mode register (address 5) stores only bit 23, and all other bits read 0. The per-pin outputs irq_pin_o are driven only while bit 23 is 1. The combined output does not depend on this bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| bus_sel | input | 1 | Bus access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_pin_o | output | NUM_PINS | Per-pin interrupt lines (individual mode) |
| irq_any_o | output | 1 | OR of all qualified pin requests |

## Verification
The bench targets the reversed bit ordering, which has two failure modes. A design that reverses it wrongly on the source or mask registers would acknowledge or mask the wrong pin. A design that got the field offset wrong would apply one pin's sense code to its neighbour. The bench also checks the write-zero acknowledge: if it were inverted, writing ones would wipe every request. It checks that a clear written against an active level is undone at once; a design that let the clear win would lose a request that is still asserted. It checks the three-edge latency, the gating by a zero priority, the silence of invalid codes, and the split between the individual-mode outputs and the combined line.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

    typedef enum logic [3:0] {
        SNS_FALL = 4'd0,
        SNS_RISE = 4'd1,
        SNS_LOW  = 4'd2,
        SNS_HIGH = 4'd3,
        SNS_BOTH = 4'd4
    } sense_e;

    typedef enum logic [2:0] {
        ADR_SENSE = 3'd0,
        ADR_PRIO  = 3'd1,
        ADR_SRC   = 3'd2,
        ADR_MSET  = 3'd3,
        ADR_MCLR  = 3'd4,
        ADR_MODE  = 3'd5
    } addr_e;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } pin_evt_t;

    localparam int PRIO_W = 4;

    // lowest bit of pin's field when fields are packed from bit 31 down
    function automatic int field_lsb(input int pin, input int w);
        return 32 - (pin + 1) * w;
    endfunction

    // reversed single-bit position of pin in a register of width w
    function automatic int rev_bit(input int pin, input int w);
        return w - 1 - pin;
    endfunction

    function automatic logic sense_hit(input logic [3:0] code, input pin_evt_t e);
        logic h;
        case (code)
            SNS_FALL: h = e.fall;
            SNS_RISE: h = e.rise;
            SNS_LOW:  h = ~e.lvl;
            SNS_HIGH: h = e.lvl;
            SNS_BOTH: h = e.rise | e.fall;
            default:  h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/pinirq_detect.sv
module pinirq_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pin_i,
    output pinirq_pkg::pin_evt_t evt_o
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= sync_q[TOP];
        end
    end

    always_comb begin
        evt_o.lvl  = sync_q[TOP];
        evt_o.rise = sync_q[TOP] & ~prev_q;
        evt_o.fall = ~sync_q[TOP] & prev_q;
    end
endmodule

// File: rtl/pinirq_regs.sv
module pinirq_regs #(
    parameter int NUM_PINS = 8,
    parameter int SRC_W    = 8,
    parameter int MODE_BIT = 23
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [2:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] hit_i,
    output logic [31:0]         sense_q,
    output logic [31:0]         prio_q,
    output logic [NUM_PINS-1:0] mask_q,
    output logic [NUM_PINS-1:0] pend_q,
    output logic                mode_q
);
    import pinirq_pkg::*;

    logic                wr;
    logic [NUM_PINS-1:0] wbits;
    logic [NUM_PINS-1:0] keep;

    assign wr = bus_sel & bus_we;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_map
        localparam int RB = rev_bit(g, SRC_W);
        assign wbits[g] = bus_wdata[RB];
    end

    assign keep = (wr && bus_addr == ADR_SRC) ? wbits : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q <= '0;
            prio_q  <= '0;
            mode_q  <= 1'b0;
            mask_q  <= '1;
            pend_q  <= '0;
        end else begin
            if (wr) begin
                case (bus_addr)
                    ADR_SENSE: sense_q <= bus_wdata;
                    ADR_PRIO:  prio_q  <= bus_wdata;
                    ADR_MSET:  mask_q  <= mask_q | wbits;
                    ADR_MCLR:  mask_q  <= mask_q & ~wbits;
                    ADR_MODE:  mode_q  <= bus_wdata[MODE_BIT];
                    default:   ;
                endcase
            end
            pend_q <= (pend_q & keep) | hit_i;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (bus_addr)
                ADR_SENSE: bus_rdata = sense_q;
                ADR_PRIO:  bus_rdata = prio_q;
                ADR_SRC: begin
                    for (int n = 0; n < NUM_PINS; n++)
                        bus_rdata[SRC_W-1-n] = pend_q[n];
                end
                ADR_MODE:  bus_rdata[MODE_BIT] = mode_q;
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl #(
    parameter int NUM_PINS    = 8,
    parameter int SENSE_W     = 4,
    parameter int SRC_W       = 8,
    parameter int MODE_BIT    = 23,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [2:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_PINS-1:0] irq_pin_o,
    output logic                irq_any_o
);
    import pinirq_pkg::*;

    logic [31:0]         sense_q;
    logic [31:0]         prio_q;
    logic [NUM_PINS-1:0] mask_q;
    logic [NUM_PINS-1:0] pend_q;
    logic                mode_q;
    logic [NUM_PINS-1:0] hit;
    logic [NUM_PINS-1:0] prio_nz;
    logic [NUM_PINS-1:0] qual;

    pinirq_regs #(
        .NUM_PINS (NUM_PINS),
        .SRC_W    (SRC_W),
        .MODE_BIT (MODE_BIT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hit_i     (hit),
        .sense_q   (sense_q),
        .prio_q    (prio_q),
        .mask_q    (mask_q),
        .pend_q    (pend_q),
        .mode_q    (mode_q)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        localparam int SL = field_lsb(g, SENSE_W);
        localparam int PL = field_lsb(g, PRIO_W);
        pin_evt_t    evt;
        logic [3:0]  code;

        pinirq_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk   (clk),
            .rst   (rst),
            .pin_i (pin_i[g]),
            .evt_o (evt)
        );

        assign code       = 4'(sense_q[SL +: SENSE_W]);
        assign hit[g]     = sense_hit(code, evt);
        assign prio_nz[g] = |prio_q[PL +: PRIO_W];
        assign qual[g]    = pend_q[g] & ~mask_q[g] & prio_nz[g];
    end

    assign irq_pin_o = mode_q ? qual : '0;
    assign irq_any_o = |qual;
endmodule

// File: rtl/pinirq_checker.sv
module pinirq_checker #(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_sel,
    input logic                bus_we,
    input logic [2:0]          bus_addr,
    input logic [31:0]         bus_rdata,
    input logic [NUM_PINS-1:0] irq_pin_o,
    input logic                irq_any_o,
    input logic [NUM_PINS-1:0] mask_q,
    input logic [NUM_PINS-1:0] prio_nz,
    input logic                mode_q
);
    // R1
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_any_o == 1'b0 && irq_pin_o == '0));

    // R7
    a_r7_wo_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && (bus_addr == 3'd3 || bus_addr == 3'd4)) |-> bus_rdata == 32'd0);

    // R7
    a_r7_masked_silent: assert property (@(posedge clk) disable iff (rst)
        (irq_pin_o & mask_q) == '0);

    // R8
    a_r8_prio_gate: assert property (@(posedge clk) disable iff (rst)
        (irq_pin_o & ~prio_nz) == '0);

    // R10
    a_r10_mode_off: assert property (@(posedge clk) disable iff (rst)
        !mode_q |-> irq_pin_o == '0);

    // R9
    a_r9_any_matches: assert property (@(posedge clk) disable iff (rst)
        mode_q |-> (irq_any_o == (|irq_pin_o)));
endmodule

bind pinirq_ctrl pinirq_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_pin_o (irq_pin_o),
    .irq_any_o (irq_any_o),
    .mask_q    (mask_q),
    .prio_nz   (prio_nz),
    .mode_q    (mode_q)
);

// File: tb/pinirq_ctrl_tb.sv
module pinirq_ctrl_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pins = 8'b0000_0100;
    logic          sel = 1'b0;
    logic          we = 1'b0;
    logic [2:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] irq_pin;
    logic          irq_any;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    event  mon_ev;

    always #2.5 clk = ~clk;

    pinirq_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .pin_i     (pins),
        .bus_sel   (sel),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_pin_o (irq_pin),
        .irq_any_o (irq_any)
    );

    // monitor: pops expected read data and compares
    initial begin
        forever begin
            @(mon_ev);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_tests++;
                if (rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd_expect(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        #1 -> mon_ev;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic chk_irq(input logic [NP-1:0] ep, input logic ea, input string tag);
        n_tests++;
        if (irq_pin !== ep || irq_any !== ea) begin
            n_fail++;
            $display("FAIL %s: irq_pin=%h irq_any=%b expected irq_pin=%h irq_any=%b",
                     tag, irq_pin, irq_any, ep, ea);
        end
    endtask

    task automatic wait3();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_irq(8'h00, 1'b0, "R1 outputs after reset");
        rd_expect(3'd0, 32'h0, "R1 sense reset");
        rd_expect(3'd1, 32'h0, "R1 prio reset");
        rd_expect(3'd2, 32'h0, "R1 source reset");
        rd_expect(3'd5, 32'h0, "R1 mode reset");

        // R2 pin0 rise, pin1 fall, pin2 low, pin3 high, pin4 both, pin5 invalid, pins6/7 rise
        bus_write(3'd0, 32'h1023_4711);
        rd_expect(3'd0, 32'h1023_4711, "R2 sense readback");
        bus_write(3'd1, 32'hFFFF_FFFF);
        rd_expect(3'd1, 32'hFFFF_FFFF, "R2 prio readback");
        bus_write(3'd5, 32'hFFFF_FFFF);
        rd_expect(3'd5, 32'h0080_0000, "R10 mode only bit 23");
        bus_write(3'd2, 32'h0);
        bus_write(3'd4, 32'h0000_00FF);
        rd_expect(3'd4, 32'h0, "R7 mask-clear reads 0");
        rd_expect(3'd3, 32'h0, "R7 mask-set reads 0");
        chk_irq(8'h00, 1'b0, "R1 idle after unmask");

        // R3 rising edge on pin0, latency
        pins[0] = 1'b1;
        repeat (2) @(negedge clk);
        chk_irq(8'h00, 1'b0, "R3 not yet after two edges");
        @(negedge clk);
        chk_irq(8'h01, 1'b1, "R3 rise pin0 after third edge");
        rd_expect(3'd2, 32'h80, "R6 pin0 at bit 7");
        bus_write(3'd2, 32'hFF);
        rd_expect(3'd2, 32'h80, "R6 writing ones keeps");
        bus_write(3'd2, 32'h7F);
        rd_expect(3'd2, 32'h00, "R6 writing zero clears");

        // R3 falling edge on pin1
        pins[1] = 1'b1;
        wait3();
        rd_expect(3'd2, 32'h00, "R3 falling code ignores rise");
        pins[1] = 1'b0;
        wait3();
        chk_irq(8'h02, 1'b1, "R3 fall pin1");
        rd_expect(3'd2, 32'h40, "R6 pin1 at bit 6");
        bus_write(3'd2, 32'h0);

        // R3 both edges on pin4
        pins[4] = 1'b1;
        wait3();
        rd_expect(3'd2, 32'h08, "R3 both-edge rise pin4");
        bus_write(3'd2, 32'h0);
        pins[4] = 1'b0;
        wait3();
        rd_expect(3'd2, 32'h08, "R3 both-edge fall pin4");
        bus_write(3'd2, 32'h0);

        // R5 invalid code on pin5
        pins[5] = 1'b1;
        wait3();
        pins[5] = 1'b0;
        wait3();
        rd_expect(3'd2, 32'h00, "R5 invalid code no pending");
        chk_irq(8'h00, 1'b0, "R5 invalid code no irq");

        // R4 level high on pin3
        pins[3] = 1'b1;
        wait3();
        rd_expect(3'd2, 32'h10, "R4 high level pending");
        bus_write(3'd2, 32'h0);
        rd_expect(3'd2, 32'h10, "R4 clear does not stick while high");
        pins[3] = 1'b0;
        wait3();
        bus_write(3'd2, 32'h0);
        rd_expect(3'd2, 32'h00, "R4 clear sticks after level drops");

        // R4 level low on pin2
        pins[2] = 1'b0;
        wait3();
        rd_expect(3'd2, 32'h20, "R4 low level pending");
        pins[2] = 1'b1;
        wait3();
        bus_write(3'd2, 32'h0);
        rd_expect(3'd2, 32'h00, "R4 low level released");

        // R7 masking of pin0 (bit 7)
        bus_write(3'd3, 32'h80);
        pins[0] = 1'b0;
        wait3();
        pins[0] = 1'b1;
        wait3();
        rd_expect(3'd2, 32'h80, "R7 masked pin still pends");
        chk_irq(8'h00, 1'b0, "R7 masked pin silent");
        bus_write(3'd3, 32'h00);
        bus_write(3'd4, 32'h00);
        chk_irq(8'h00, 1'b0, "R7 zero writes have no effect");
        bus_write(3'd4, 32'h80);
        chk_irq(8'h01, 1'b1, "R7 mask-clear unmasks pin0");

        // R8 priority gating of pin0 (bits 31:28)
        bus_write(3'd1, 32'h0FFF_FFFF);
        chk_irq(8'h00, 1'b0, "R8 zero priority blocks");
        bus_write(3'd1, 32'h1FFF_FFFF);
        chk_irq(8'h01, 1'b1, "R8 nonzero priority passes");

        // R9 two pins
        pins[6] = 1'b1;
        wait3();
        chk_irq(8'h41, 1'b1, "R9 two pins pending");

        // R10 mode bit
        bus_write(3'd5, 32'hFF7F_FFFF);
        rd_expect(3'd5, 32'h0, "R10 mode cleared");
        chk_irq(8'h00, 1'b1, "R10 per-pin off, combined on");
        bus_write(3'd5, 32'h0080_0000);
        chk_irq(8'h41, 1'b1, "R10 per-pin restored");

        bus_write(3'd2, 32'h0);
        chk_irq(8'h00, 1'b0, "R6 write zero clears all");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule